// File: doc/BRIEF.md
# DVB-ASI Fill-Character Output Controller

This block sits in front of an 8b/10b serializer and turns one of two byte sources into a continuous transport-stream symbol flow. One source is a clocked FIFO that offers a byte with an active-low request sampled on the clock edge. The other is an asynchronous FIFO that presents a byte and pulls a strobe low. The strobe is brought into the clock domain through a flop chain, and every falling edge yields exactly one byte. In any cycle in which no byte is ready, the block drives the K28.5 comma code with the special-character flag raised, so that the serializer always has a symbol to send.

A single mode input shares the same output port with a video path. In that path each byte is scrambled bit-serially with the x^9 + x^4 + 1 polynomial and then NRZI coded. In transport-stream mode that path is frozen and bytes leave untouched. All outputs are registered. An enable output tells the serializer when the symbol stream is live.

Top module: `asifill_ctrl`

## Requirements
- R1: While reset is sampled high, and afterwards in transport mode until a byte is offered, the output is the fill symbol: dout = 0xBC with dout_k = 1.
- R2: When sync_req_n is sampled low at a rising edge in transport mode, the din byte from that edge is on dout with dout_k = 0 after that edge.
- R3: The async_strobe_n input passes through two synchronizing flops. The din byte is taken at the third rising edge that samples the strobe low, and it shows on dout after that edge. Each falling edge of the strobe gives one byte, however long the strobe stays low. The source holds the strobe low and din stable for at least three cycles.
- R4: A transport-mode cycle that has no sync request, no held byte and no strobe detection outputs 0xBC with dout_k = 1. dout_k = 1 is never paired with any other byte.
- R5: A sync request wins over a strobe detection in the same cycle. The strobe byte is then kept in a one-entry holding slot and is sent in the first later transport cycle that has no sync request, ahead of any newer strobe byte. A strobe detection that arrives while the slot is full and a sync request is active is discarded.
- R6: With asi_mode = 0, both enables are ignored and every output symbol has dout_k = 0. Strobe detections made in this mode are not sent after the block returns to transport mode.
- R7: In video mode each byte is scrambled LSB first as s = d xor s(n-4) xor s(n-9) and then NRZI coded as q = s xor q(n-1). Both histories are zero after reset and advance only in video cycles, so din = 0x01 as the first video byte after reset gives 0x0F.
- R8: ser_en is 0 after any rising edge that samples reset high, and 1 after every other edge.
- R9: A video-mode cycle empties the holding slot, so a byte held back under R5 is lost if the mode leaves transport before the byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous reset, active high |
| asi_mode | input | 1 | 1 = transport-stream mode, 0 = scrambled video mode |
| sync_req_n | input | 1 | Active-low byte request from a clocked FIFO |
| async_strobe_n | input | 1 | Active-low byte strobe from an asynchronous FIFO |
| din | input | 8 | Byte from either FIFO, or the video byte |
| dout | output | 8 | Symbol byte to the serializer |
| dout_k | output | 1 | 1 = special character (fill), 0 = data |
| ser_en | output | 1 | Serializer enable |

## Verification
The collision of interest is a clocked-FIFO request in the same cycle as a strobe detection that the synchronizer produces. The bench holds sync_req_n low across the third edge after a strobe fall. It then checks that the clocked byte goes out first and that the strobe byte follows in the first free cycle. A second strobe fall is placed inside a long request burst while the slot is already full, and the bench expects exactly one data byte once the burst ends. A behavioural reference model tracks the strobe history, the slot and the scrambler bit history, and it is compared with the outputs on every clock, including a long stretch of pseudo-random mode, request and strobe traffic.

// File: rtl/asifill_pkg.sv
package asifill_pkg;

    localparam int BYTE_W       = 8;
    localparam int SYNC_STAGES  = 2;
    localparam int SCR_TAP_NEAR = 4;
    localparam int SCR_TAP_FAR  = 9;

    typedef logic [BYTE_W-1:0] byte_t;

    // K28.5 comma expressed as the 8-bit value with the special flag set
    localparam byte_t FILL_CODE = BYTE_W'(8'hBC);

    typedef struct packed {
        byte_t data;
        logic  is_k;
    } sym_t;

    typedef enum logic [1:0] {
        SRC_FILL  = 2'd0,
        SRC_SYNC  = 2'd1,
        SRC_SLOT  = 2'd2,
        SRC_ASYNC = 2'd3
    } src_e;

    function automatic sym_t fill_sym();
        sym_t s;
        s.data = FILL_CODE;
        s.is_k = 1'b1;
        return s;
    endfunction

    function automatic sym_t data_sym(byte_t b);
        sym_t s;
        s.data = b;
        s.is_k = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/asifill_strobe_sync.sv
module asifill_strobe_sync
    import asifill_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic fall
);
    localparam int LAST = STAGES;

    // chain[0] is the first capture flop, chain[LAST] the edge-history flop
    logic [LAST:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[LAST-1:0], strobe_n};
        end
    end

    assign fall = chain_q[LAST] & ~chain_q[LAST-1];

endmodule

// File: rtl/asifill_arbiter.sv
module asifill_arbiter
    import asifill_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  asi_mode,
    input  logic  sync_req_n,
    input  logic  fall,
    input  byte_t din,
    output sym_t  sym
);
    logic  slot_full_q, slot_full_d;
    byte_t slot_q, slot_d;
    src_e  src;

    // fixed priority: clocked FIFO, held byte, fresh strobe byte, fill
    always_comb begin
        if (!sync_req_n)     src = SRC_SYNC;
        else if (slot_full_q) src = SRC_SLOT;
        else if (fall)        src = SRC_ASYNC;
        else                  src = SRC_FILL;
    end

    always_comb begin
        unique case (src)
            SRC_SYNC:  sym = data_sym(din);
            SRC_SLOT:  sym = data_sym(slot_q);
            SRC_ASYNC: sym = data_sym(din);
            default:   sym = fill_sym();
        endcase
    end

    always_comb begin
        slot_full_d = slot_full_q;
        slot_d      = slot_q;
        if (!asi_mode) begin
            slot_full_d = 1'b0;
        end else begin
            unique case (src)
                SRC_SYNC: begin
                    if (fall && !slot_full_q) begin
                        slot_full_d = 1'b1;
                        slot_d      = din;
                    end
                end
                SRC_SLOT: begin
                    if (fall) begin
                        slot_d = din;
                    end else begin
                        slot_full_d = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_full_q <= 1'b0;
            slot_q      <= '0;
        end else begin
            slot_full_q <= slot_full_d;
            slot_q      <= slot_d;
        end
    end

endmodule

// File: rtl/asifill_scrambler.sv
module asifill_scrambler
    import asifill_pkg::*;
#(
    parameter int TAP_NEAR = SCR_TAP_NEAR,
    parameter int TAP_FAR  = SCR_TAP_FAR
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    input  byte_t raw,
    output byte_t coded
);
    localparam int HW = TAP_FAR;

    // hist[0] holds the most recent scrambled bit
    logic [HW-1:0] hist_q, hist_d;
    logic          nrzi_q, nrzi_d;

    always_comb begin
        logic [HW-1:0] h;
        logic          n;
        logic          s;
        h     = hist_q;
        n     = nrzi_q;
        coded = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            s        = raw[i] ^ h[TAP_NEAR-1] ^ h[TAP_FAR-1];
            h        = {h[HW-2:0], s};
            n        = n ^ s;
            coded[i] = n;
        end
        hist_d = h;
        nrzi_d = n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            nrzi_q <= 1'b0;
        end else if (advance) begin
            hist_q <= hist_d;
            nrzi_q <= nrzi_d;
        end
    end

endmodule

// File: rtl/asifill_ctrl.sv
module asifill_ctrl
    import asifill_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       asi_mode,
    input  logic       sync_req_n,
    input  logic       async_strobe_n,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       dout_k,
    output logic       ser_en
);
    logic  strobe_fall;
    sym_t  asi_sym;
    byte_t vid_byte;
    sym_t  out_q;
    logic  en_q;

    asifill_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (async_strobe_n),
        .fall     (strobe_fall)
    );

    asifill_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .asi_mode   (asi_mode),
        .sync_req_n (sync_req_n),
        .fall       (strobe_fall),
        .din        (din),
        .sym        (asi_sym)
    );

    asifill_scrambler #(
        .TAP_NEAR (SCR_TAP_NEAR),
        .TAP_FAR  (SCR_TAP_FAR)
    ) u_scr (
        .clk     (clk),
        .rst     (rst),
        .advance (!asi_mode),
        .raw     (din),
        .coded   (vid_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= fill_sym();
            en_q  <= 1'b0;
        end else begin
            en_q  <= 1'b1;
            out_q <= asi_mode ? asi_sym : data_sym(vid_byte);
        end
    end

    assign dout   = out_q.data;
    assign dout_k = out_q.is_k;
    assign ser_en = en_q;

endmodule

// File: rtl/asifill_ctrl_chk.sv
module asifill_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       asi_mode,
    input logic       sync_req_n,
    input logic [7:0] din,
    input logic [7:0] dout,
    input logic       dout_k,
    input logic       ser_en
);
    logic prev_live;

    always_ff @(posedge clk) prev_live <= !rst;

    // R4: the special flag only ever accompanies the comma byte
    assert_fill_code_R4: assert property (@(posedge clk) disable iff (rst)
        dout_k |-> (dout == 8'hBC));

    // R2 and R5: a clocked request is sent on the next edge ahead of all else
    assert_sync_first_R5: assert property (@(posedge clk) disable iff (rst)
        (asi_mode && !sync_req_n) |=> (!dout_k && dout == $past(din)));

    // R6: video cycles never produce a special character
    assert_video_data_R6: assert property (@(posedge clk) disable iff (rst)
        !asi_mode |=> !dout_k);

    // R8: enable is high once a non-reset edge has passed
    assert_ser_en_R8: assert property (@(posedge clk) disable iff (rst)
        prev_live |-> ser_en);

endmodule

bind asifill_ctrl asifill_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .asi_mode   (asi_mode),
    .sync_req_n (sync_req_n),
    .din        (din),
    .dout       (dout),
    .dout_k     (dout_k),
    .ser_en     (ser_en)
);

// File: tb/asifill_ctrl_bench.sv
module asifill_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       asi_mode = 1'b1;
    logic       sync_req_n = 1'b1;
    logic       async_strobe_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_k;
    logic       ser_en;

    always #10 clk = ~clk;

    asifill_ctrl u_asifill_ctrl (
        .clk            (clk),
        .rst            (rst),
        .asi_mode       (asi_mode),
        .sync_req_n     (sync_req_n),
        .async_strobe_n (async_strobe_n),
        .din            (din),
        .dout           (dout),
        .dout_k         (dout_k),
        .ser_en         (ser_en)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    done = 1'b0;
    bit    model_ok = 1'b0;

    // behavioural reference
    logic [7:0] m_d;
    bit         m_k, m_en;
    bit         st_hist[3];
    bit         held;
    logic [7:0] held_v;
    bit         sbits[$];
    bit         last_q;

    always @(posedge clk) begin : model
        bit         fell;
        logic [7:0] o;
        if (rst) begin
            model_ok = 1'b1;
            m_d = 8'hBC; m_k = 1'b1; m_en = 1'b0;
            foreach (st_hist[i]) st_hist[i] = 1'b1;
            held = 1'b0; held_v = 8'h00;
            sbits.delete();
            repeat (9) sbits.push_back(1'b0);
            last_q = 1'b0;
        end else begin
            fell = st_hist[2] && !st_hist[1];
            st_hist[2] = st_hist[1];
            st_hist[1] = st_hist[0];
            st_hist[0] = async_strobe_n;
            m_en = 1'b1;
            if (asi_mode) begin
                if (!sync_req_n) begin
                    m_d = din; m_k = 1'b0;
                    if (fell && !held) begin held = 1'b1; held_v = din; end
                end else if (held) begin
                    m_d = held_v; m_k = 1'b0;
                    if (fell) held_v = din; else held = 1'b0;
                end else if (fell) begin
                    m_d = din; m_k = 1'b0;
                end else begin
                    m_d = 8'hBC; m_k = 1'b1;
                end
            end else begin
                held = 1'b0;
                for (int i = 0; i < 8; i++) begin
                    bit s;
                    s = din[i] ^ sbits[sbits.size()-4] ^ sbits[sbits.size()-9];
                    sbits.push_back(s);
                    void'(sbits.pop_front());
                    last_q = last_q ^ s;
                    o[i] = last_q;
                end
                m_d = o; m_k = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (model_ok && !done) begin
            checks++;
            if (dout !== m_d || dout_k !== m_k || ser_en !== m_en) begin
                errors++;
                $display("FAIL %s model compare: got d=%h k=%b en=%b expected d=%h k=%b en=%b",
                         tag, dout, dout_k, ser_en, m_d, m_k, m_en);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s directed: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] seed;
        int          nk;
        seed = 32'h1234_5678;

        // R1 and R8: reset state
        tick(3);
        chk(dout == 8'hBC && dout_k, "R1", dout, 8'hBC);
        chk(ser_en == 1'b0, "R8", ser_en, 0);
        rst = 1'b0;
        tick(1);
        chk(dout == 8'hBC && dout_k, "R1", dout, 8'hBC);
        chk(ser_en == 1'b1, "R8", ser_en, 1);
        tick(2);

        // R2: clocked FIFO bytes
        tag = "R2";
        sync_req_n = 1'b0; din = 8'h11;
        tick(1);
        chk(dout == 8'h11 && !dout_k, "R2", dout, 8'h11);
        din = 8'h22;
        tick(1);
        chk(dout == 8'h22 && !dout_k, "R2", dout, 8'h22);
        sync_req_n = 1'b1;
        tick(1);
        // R4: fill when idle
        chk(dout == 8'hBC && dout_k, "R4", dout, 8'hBC);
        tag = "R4";
        tick(3);

        // R3: asynchronous strobe, one byte per fall
        tag = "R3";
        din = 8'hA5; async_strobe_n = 1'b0;
        tick(2);
        chk(dout_k == 1'b1, "R3", dout, 8'hBC);
        tick(1);
        chk(dout == 8'hA5 && !dout_k, "R3", dout, 8'hA5);
        tick(1);
        chk(dout == 8'hBC && dout_k, "R3", dout, 8'hBC);
        tick(3);
        chk(dout == 8'hBC && dout_k, "R3", dout, 8'hBC);
        async_strobe_n = 1'b1;
        tick(4);

        // R5: collision, strobe byte deferred
        tag = "R5";
        din = 8'h40; sync_req_n = 1'b0; async_strobe_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            din = din + 8'h01;
        end
        sync_req_n = 1'b1; din = 8'h99;
        tick(1);
        chk(dout == 8'h42 && !dout_k, "R5", dout, 8'h42);
        tick(1);
        chk(dout == 8'hBC && dout_k, "R5", dout, 8'hBC);
        async_strobe_n = 1'b1;
        tick(4);

        // R5: second fall during a long burst with the slot full is dropped
        din = 8'h60; sync_req_n = 1'b0; async_strobe_n = 1'b0;
        tick(3);
        async_strobe_n = 1'b1;
        tick(3);
        async_strobe_n = 1'b0; din = 8'h61;
        tick(4);
        sync_req_n = 1'b1; async_strobe_n = 1'b1;
        nk = 0;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            if (!dout_k) nk++;
        end
        chk(nk == 1, "R5", nk, 1);

        // R9: video cycle empties the slot
        tag = "R9";
        din = 8'h70; sync_req_n = 1'b0; async_strobe_n = 1'b0;
        tick(3);
        asi_mode = 1'b0; sync_req_n = 1'b1;
        tick(1);
        chk(!dout_k, "R6", dout_k, 0);
        asi_mode = 1'b1;
        tick(1);
        chk(dout == 8'hBC && dout_k, "R9", dout, 8'hBC);
        async_strobe_n = 1'b1;
        tick(4);

        // R6: enables ignored in video mode
        tag = "R6";
        asi_mode = 1'b0; async_strobe_n = 1'b0; sync_req_n = 1'b0; din = 8'h33;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            chk(!dout_k, "R6", dout_k, 0);
        end
        sync_req_n = 1'b1; async_strobe_n = 1'b1;
        tick(1);
        asi_mode = 1'b1;
        tick(1);
        chk(dout == 8'hBC && dout_k, "R6", dout, 8'hBC);
        tick(4);

        // R7: scrambler from a fresh reset
        tag = "R7";
        rst = 1'b1;
        tick(2);
        rst = 1'b0; asi_mode = 1'b0; din = 8'h01;
        tick(1);
        chk(dout == 8'h0F && !dout_k, "R7", dout, 8'h0F);
        for (int i = 0; i < 40; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            din = seed[23:16];
            tick(1);
        end

        // mixed traffic, all compared against the model
        tag = "R5";
        for (int i = 0; i < 400; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            din = seed[15:8];
            sync_req_n = seed[20] | seed[21];
            if (seed[27:24] == 4'd0) asi_mode = ~asi_mode;
            if (seed[31:29] == 3'd0) async_strobe_n = ~async_strobe_n;
            tick(1);
        end
        tick(2);
        finish_run();
    end

endmodule